// File: doc/BRIEF.md
# Command/Data Transmit Queue with Runtime Collapse

This block sits between software and a serial engine on the transmit side. Each entry holds a command word and a data word, and both are written through a single push port in one cycle. The engine takes the oldest entry through a pop port. The head entry is always visible at the output while the queue holds anything, so the engine reads the head and pops it in the same cycle.

Three status outputs describe the queue. A fill request is high while there is room. A sticky underflow flag records a pop into an empty queue. An entry counter gives the current occupancy. A disable input shrinks the capacity from five entries to one, which turns the block into a plain double buffer. The status outputs keep the same meaning for that single slot. The disable setting is chosen while the block is held in reset, before the first push. Changing it afterwards is not supported.

Occupancy is tracked by a three-state machine:
- In EMPTY there is no entry.
- In PARTIAL at least one slot is used and at least one is free.
- In FULL occupancy equals the capacity.

The named transitions are:
- FILL_FIRST: EMPTY to PARTIAL on a push with capacity 5.
- FILL_ONLY: EMPTY to FULL on a push with capacity 1.
- TOP_UP: PARTIAL to FULL when a push takes the last free slot.
- DRAIN_LAST: PARTIAL to EMPTY when the last entry is popped.
- FREE_ONE: FULL to PARTIAL on a pop with capacity 5.
- FREE_ONLY: FULL to EMPTY on a pop with capacity 1.

Every other combination of inputs keeps the current state, including a push together with a pop.

Top module: `cmdq_tx`

## Requirements
- R1: After reset the entry count is 0, fill request is 1, underflow is 0 and head_valid is 0.
- R2: Entries leave in the order they were pushed. The command and data of an entry stay paired, and the head entry is shown on head_cmd/head_data whenever head_valid is 1.
- R3: fill_req is 1 exactly when the entry count is below the capacity. The capacity is 5 when fifo_off is 0 and 1 when fifo_off is 1.
- R4: entry_count equals the number of stored entries and never exceeds the capacity. It rises by one on an accepted push and falls by one on a pop of a non-empty queue.
- R5: A push into a full queue with no pop in the same cycle is dropped. The count and all stored entries are unchanged.
- R6: A push and a pop in the same cycle on a non-empty queue, including a full one, leave the count unchanged. The popped entry is the old head and the pushed entry joins the tail.
- R7: A pop of an empty queue sets underflow and removes nothing. A push in that same cycle is still accepted.
- R8: underflow stays set until uf_clr is 1 in a cycle without a new underflow, and then clears. A new underflow in the same cycle as uf_clr keeps it set.
- R9: With fifo_off at 1 the queue holds a single entry. A second push without a pop is dropped, and the fill, underflow and count outputs follow R3 to R8 with capacity 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_off | input | 1 | 1 collapses the queue to one entry; set before the first push |
| push_valid | input | 1 | Push request from software |
| push_cmd | input | CMD_W | Command word of the pushed entry |
| push_data | input | DATA_W | Data word of the pushed entry |
| pop_req | input | 1 | Pop request from the engine |
| uf_clr | input | 1 | Write-one clear of the underflow flag |
| head_valid | output | 1 | Queue holds at least one entry |
| head_cmd | output | CMD_W | Command word of the oldest entry |
| head_data | output | DATA_W | Data word of the oldest entry |
| fill_req | output | 1 | Room for at least one more entry |
| underflow | output | 1 | Sticky flag for a pop of an empty queue |
| entry_count | output | CNT_W | Number of stored entries |

## Verification
A corrupted occupancy state or count shows up in the cycle after the faulty update: entry_count, fill_req or head_valid disagree with the reference on the next falling edge. A wrong read or write pointer shows up only when the affected entry reaches the head, which can be up to four pops later in five-entry mode. For that reason the stimulus drains the queue completely and compares every head word. Underflow mistakes are seen one cycle after the pop or clear that caused them, because the flag is registered.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
    parameter int DEPTH  = 5,
    parameter int WORD_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] slot_q [DEPTH];

    // One register per slot; no reset is needed because occupancy gates every read.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(s))) begin
                slot_q[s] <= wr_word;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (rd_ptr == PTR_W'(s)) begin
                rd_word = slot_q[s];
            end
        end
    end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_off,
    input  logic             push,
    input  logic             pop,
    input  logic             uf_clr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             fill_req,
    output logic             underflow,
    output logic             head_valid
);
    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] cap;
    logic             pop_ok, push_ok, uf_hit;

    assign cap     = fifo_off ? CNT_W'(1) : CNT_W'(DEPTH);
    assign pop_ok  = pop && (state_q != Q_EMPTY);
    assign push_ok = push && ((state_q != Q_FULL) || pop_ok);
    assign uf_hit  = pop && (state_q == Q_EMPTY);
    assign wr_en   = push_ok;

    // Next occupancy state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (push_ok) begin
                    state_d = (cap == CNT_W'(1)) ? Q_FULL : Q_PARTIAL;      // FILL_ONLY / FILL_FIRST
                end
            end
            Q_PARTIAL: begin
                if (push_ok && !pop_ok && (count + CNT_W'(1) == cap)) begin
                    state_d = Q_FULL;                                       // TOP_UP
                end else if (pop_ok && !push_ok && (count == CNT_W'(1))) begin
                    state_d = Q_EMPTY;                                      // DRAIN_LAST
                end
            end
            Q_FULL: begin
                if (pop_ok && !push_ok) begin
                    state_d = (cap == CNT_W'(1)) ? Q_EMPTY : Q_PARTIAL;     // FREE_ONLY / FREE_ONE
                end
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Count, pointers and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            underflow <= 1'b0;
        end else begin
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);

            if (fifo_off) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
                if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end

            if (uf_hit)      underflow <= 1'b1;
            else if (uf_clr) underflow <= 1'b0;
        end
    end

    // Outputs derived from state.
    always_comb begin
        head_valid = 1'b0;
        fill_req   = 1'b1;
        unique case (state_q)
            Q_EMPTY:   begin head_valid = 1'b0; fill_req = 1'b1; end
            Q_PARTIAL: begin head_valid = 1'b1; fill_req = 1'b1; end
            Q_FULL:    begin head_valid = 1'b1; fill_req = 1'b0; end
            default:   begin head_valid = 1'b0; fill_req = 1'b1; end
        endcase
    end

    // R4
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= cap);
    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && push && !pop) |=> $stable(count));
    // R6
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != Q_EMPTY && push && pop) |=> $stable(count));
    // R7
    uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY && pop) |=> underflow);
    // R8
    uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !uf_clr) |=> underflow);
    // R9
    off_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_off |-> (count <= CNT_W'(1)));
endmodule

// File: rtl/cmdq_tx.sv
module cmdq_tx #(
    parameter int DEPTH  = 5,
    parameter int CMD_W  = 16,
    parameter int DATA_W = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WORD_W = CMD_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_off,
    input  logic              push_valid,
    input  logic [CMD_W-1:0]  push_cmd,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              uf_clr,
    output logic              head_valid,
    output logic [CMD_W-1:0]  head_cmd,
    output logic [DATA_W-1:0] head_data,
    output logic              fill_req,
    output logic              underflow,
    output logic [CNT_W-1:0]  entry_count
);
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [WORD_W-1:0] rd_word;

    cmdq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_off   (fifo_off),
        .push       (push_valid),
        .pop        (pop_req),
        .uf_clr     (uf_clr),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (entry_count),
        .fill_req   (fill_req),
        .underflow  (underflow),
        .head_valid (head_valid)
    );

    cmdq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_word ({push_cmd, push_data}),
        .rd_ptr  (rd_ptr),
        .rd_word (rd_word)
    );

    assign head_cmd  = rd_word[WORD_W-1:DATA_W];
    assign head_data = rd_word[DATA_W-1:0];
endmodule

// File: tb/cmdq_tx_bench.sv
module cmdq_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_off = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_cmd = '0;
    logic [15:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic        uf_clr = 1'b0;
    logic        head_valid, fill_req, underflow;
    logic [15:0] head_cmd, head_data;
    logic [2:0]  entry_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [31:0] mq[$];
    bit          muf = 0;

    always #2 clk = ~clk;

    cmdq_tx u_cmdq_tx (
        .clk(clk), .rst_n(rst_n), .fifo_off(fifo_off),
        .push_valid(push_valid), .push_cmd(push_cmd), .push_data(push_data),
        .pop_req(pop_req), .uf_clr(uf_clr),
        .head_valid(head_valid), .head_cmd(head_cmd), .head_data(head_data),
        .fill_req(fill_req), .underflow(underflow), .entry_count(entry_count)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on the same edge the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            muf = 0;
        end else begin
            int  cap;
            int  sz;
            bit  did_pop;
            cap = fifo_off ? 1 : 5;
            sz  = mq.size();
            did_pop = pop_req && (sz != 0);
            if (pop_req && sz == 0) muf = 1;
            else if (uf_clr)        muf = 0;
            if (did_pop) void'(mq.pop_front());
            if (push_valid && (sz < cap || did_pop)) mq.push_back({push_cmd, push_data});
        end
    end

    // Compare every cycle on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int cap;
            cap = fifo_off ? 1 : 5;
            chk("R4", "entry_count", 32'(entry_count), 32'(mq.size()));
            chk("R3", "fill_req", 32'(fill_req), 32'(mq.size() < cap));
            chk("R8", "underflow", 32'(underflow), 32'(muf));
            chk("R2", "head_valid", 32'(head_valid), 32'(mq.size() != 0));
            if (mq.size() != 0) chk("R2", "head", {head_cmd, head_data}, mq[0]);
        end
    end

    task automatic step(input bit p, input logic [15:0] c, input logic [15:0] d, input bit q, input bit clr);
        @(negedge clk);
        #1;
        push_valid = p; push_cmd = c; push_data = d; pop_req = q; uf_clr = clr;
    endtask

    task automatic settle;
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input bit off);
        @(negedge clk);
        #1;
        rst_n = 0; fifo_off = off;
        push_valid = 0; pop_req = 0; uf_clr = 0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1;
        @(negedge clk);
        #1;
    endtask

    initial begin
        do_reset(0);
        // R1 reset state
        chk("R1", "count", 32'(entry_count), 0);
        chk("R1", "fill_req", 32'(fill_req), 1);
        chk("R1", "underflow", 32'(underflow), 0);
        chk("R1", "head_valid", 32'(head_valid), 0);

        // R2 order with three entries
        for (int i = 0; i < 3; i++) step(1, 16'hC000 + 16'(i), 16'hD000 + 16'(i), 0, 0);
        settle();
        chk("R2", "first head", {head_cmd, head_data}, 32'hC000_D000);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
        settle();

        // R5 six pushes, the last is dropped
        for (int i = 0; i < 6; i++) step(1, 16'hA100 + 16'(i), 16'hB100 + 16'(i), 0, 0);
        settle();
        chk("R5", "count full", 32'(entry_count), 5);
        chk("R5", "fill_req full", 32'(fill_req), 0);
        chk("R5", "head unchanged", {head_cmd, head_data}, 32'hA100_B100);

        // R6 push and pop together while full
        step(1, 16'h6666, 16'h7777, 1, 0);
        settle();
        chk("R6", "count kept", 32'(entry_count), 5);
        chk("R6", "new head", {head_cmd, head_data}, 32'hA101_B101);

        // R7 drain then over-pop
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0);
        settle();
        chk("R7", "underflow set", 32'(underflow), 1);
        chk("R7", "count zero", 32'(entry_count), 0);
        // R7 pop on empty with push: entry accepted
        step(1, 16'h1234, 16'h5678, 1, 0);
        settle();
        chk("R7", "push accepted", 32'(entry_count), 1);

        // R8 clear, then clear colliding with a new underflow
        step(0, 0, 0, 1, 1);
        settle();
        chk("R8", "cleared after pop", 32'(underflow), 0);
        step(0, 0, 0, 1, 1);
        settle();
        chk("R8", "set wins over clear", 32'(underflow), 1);
        step(0, 0, 0, 0, 1);
        settle();
        chk("R8", "cleared", 32'(underflow), 0);

        // Mixed traffic, normal mode
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 7) == 0));
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0);
        settle();

        // R9 collapsed mode
        do_reset(1);
        chk("R9", "fill_req empty", 32'(fill_req), 1);
        step(1, 16'h0F0F, 16'hF0F0, 0, 0);
        step(1, 16'h1111, 16'h2222, 0, 0);
        settle();
        chk("R9", "count one", 32'(entry_count), 1);
        chk("R9", "fill_req full", 32'(fill_req), 0);
        chk("R9", "second dropped", {head_cmd, head_data}, 32'h0F0F_F0F0);
        step(1, 16'h3333, 16'h4444, 1, 0);
        settle();
        chk("R9", "swap head", {head_cmd, head_data}, 32'h3333_4444);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        settle();
        chk("R9", "underflow", 32'(underflow), 1);
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0));
        settle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule